// File: doc/BRIEF.md
# Misaligned Transfer Splitting Bus Sequencer

This block sits between a load/store unit and the address phase of a 64-bit split-transaction bus. A request carries a byte address, a length of one to four bytes and a direction. The sequencer works out whether the bytes stay inside one 8-byte double-word. If they do, it issues one transfer, even when the address is not aligned to the access size. If they spill into the next double-word, it issues two transfers back to back. The first covers the bytes up to the boundary and the second starts at offset 000 of the next double-word.

Each transfer carries a 3-bit size code, the byte address and an 8-bit byte-lane enable. The sequencer runs every address tenure the same way: a one-cycle start strobe, then a wait for acknowledge. A retry cancels the tenure and reissues the same piece. A separate request flag marks an external-control word access. That access is always four bytes long, and if it crosses a 4-byte word boundary it is rejected with a fault pulse and no bus activity.

Top module: `mis_split_seq`

## Requirements
- R1: After reset the block is idle: `req_ready_o` is 1 and `ts_o`, `done_o` and `fault_o` are 0.
- R2: A request whose bytes lie within one double-word (offset + length ≤ 8) produces exactly one tenure at the request address, for example 4 bytes at offset 1.
- R3: A request crossing a double-word boundary produces two tenures. The first is at the request address and covers 8 − offset bytes. The second is at the next double-word with low address bits 000 and covers the remaining bytes.
- R4: `bus_size_o` is the byte count of the current piece in binary: 001 = 1, 010 = 2, 011 = 3, 100 = 4.
- R5: Bit i of `bus_lanes_o` is 1 exactly when offset ≤ i < offset + size. Here offset is `bus_addr_o[2:0]`, and lane 0 is the byte at offset 000.
- R6: `ts_o` is high for one cycle. It rises in the cycle after a request is accepted. For a second piece it rises in the cycle after the acknowledge of the first piece.
- R7: A tenure ends only on `ack_i` sampled in a cycle after the strobe. An acknowledge during the strobe cycle is ignored, and address, size and lanes stay unchanged until the tenure ends.
- R8: `retry_i` in a wait cycle cancels the tenure, and the same piece is strobed again in the next cycle. Retry wins when `ack_i` is high in the same cycle.
- R9: A retry on the second piece reissues only the second piece.
- R10: `done_o` pulses for one cycle in the cycle after the acknowledge of the final piece, with `req_ready_o` high in that cycle.
- R11: With `req_ext_i` = 1, the length is four bytes whatever `req_len_i` holds. If the address low two bits are not 00, `fault_o` pulses in the next cycle and no strobe is issued.
- R12: Requests presented while a tenure is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_addr_i | input | 32 | Request byte address |
| req_len_i | input | 2 | Byte count minus one |
| req_ext_i | input | 1 | External-control word access |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_ready_o | output | 1 | Sequencer idle; request accepted when valid |
| ack_i | input | 1 | Address acknowledge |
| retry_i | input | 1 | Address retry |
| ts_o | output | 1 | Transfer start strobe |
| bus_addr_o | output | 32 | Address of current piece |
| bus_size_o | output | 3 | Size code of current piece |
| bus_lanes_o | output | 8 | Byte-lane enables of current piece |
| bus_write_o | output | 1 | Direction of current piece |
| done_o | output | 1 | Request complete pulse |
| fault_o | output | 1 | Alignment fault pulse |

## Verification
The assertions check, on every cycle, the properties that can be seen at the ports of a single tenure. These are the one-cycle strobe, the lane count matching the size code, and the lane at the address offset being enabled. They also cover the hold of address, size and lanes during a wait, the reissue of the same piece after a retry, and the absence of strobes whenever done or fault pulses. Only the bench scenarios can show the split arithmetic itself: which sizes and addresses each piece gets, that a second-piece retry leaves the first piece alone, that an early acknowledge is ignored, and that busy-time requests leave no trace.

// File: rtl/mss_pkg.sv
package mss_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_WAIT  = 2'd2
  } seq_st_e;
endpackage

// File: rtl/mss_split.sv
module mss_split #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LANE_N = 8,
  parameter int unsigned MAX_B  = 4,
  parameter int unsigned WORD_B = 4,
  localparam int unsigned OFF_W  = $clog2(LANE_N),
  localparam int unsigned WOFF_W = $clog2(WORD_B),
  localparam int unsigned LEN_W  = $clog2(MAX_B),
  localparam int unsigned SZ_W   = $clog2(MAX_B) + 1,
  localparam int unsigned SUM_W  = OFF_W + 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              ext_i,
  output logic [SZ_W-1:0]   size0_o,
  output logic [SZ_W-1:0]   size1_o,
  output logic [ADDR_W-1:0] addr1_o,
  output logic              split_o,
  output logic              fault_o
);
  logic [OFF_W-1:0] off;
  logic [SUM_W-1:0] nbytes, end_pos, head;
  logic [ADDR_W-OFF_W-1:0] dw_next;

  always_comb begin
    off     = addr_i[OFF_W-1:0];
    nbytes  = ext_i ? SUM_W'(WORD_B) : SUM_W'(len_i) + SUM_W'(1);
    end_pos = SUM_W'(off) + nbytes;
    split_o = end_pos > SUM_W'(LANE_N);
    head    = SUM_W'(LANE_N) - SUM_W'(off);
    size0_o = split_o ? SZ_W'(head) : SZ_W'(nbytes);
    size1_o = split_o ? SZ_W'(nbytes - head) : '0;
    dw_next = addr_i[ADDR_W-1:OFF_W] + (ADDR_W-OFF_W)'(1);
    addr1_o = {dw_next, {OFF_W{1'b0}}};
    fault_o = ext_i && (addr_i[WOFF_W-1:0] != '0);
  end
endmodule

// File: rtl/mss_lanes.sv
module mss_lanes #(
  parameter int unsigned LANE_N = 8,
  parameter int unsigned MAX_B  = 4,
  localparam int unsigned OFF_W = $clog2(LANE_N),
  localparam int unsigned SZ_W  = $clog2(MAX_B) + 1,
  localparam int unsigned SUM_W = OFF_W + 1
) (
  input  logic [OFF_W-1:0]  off_i,
  input  logic [SZ_W-1:0]   size_i,
  output logic [LANE_N-1:0] lanes_o
);
  logic [SUM_W-1:0] lim;
  assign lim = SUM_W'(off_i) + SUM_W'(size_i);

  for (genvar i = 0; i < LANE_N; i++) begin : g_lane
    assign lanes_o[i] = (SUM_W'(i) >= SUM_W'(off_i)) && (SUM_W'(i) < lim);
  end
endmodule

// File: rtl/mss_seq.sv
module mss_seq
  import mss_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned MAX_B  = 4,
  localparam int unsigned SZ_W  = $clog2(MAX_B) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic              fault_i,
  input  logic              split_i,
  input  logic [ADDR_W-1:0] addr0_i,
  input  logic [ADDR_W-1:0] addr1_i,
  input  logic [SZ_W-1:0]   size0_i,
  input  logic [SZ_W-1:0]   size1_i,
  input  logic              ack_i,
  input  logic              retry_i,
  output logic              idle_o,
  output logic              ts_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [SZ_W-1:0]   size_o,
  output logic              write_o,
  output logic              done_o,
  output logic              fault_o
);
  seq_st_e           st_q;
  logic              pc_q, two_q, wr_q, done_q, fault_q;
  logic [ADDR_W-1:0] addr_q [2];
  logic [SZ_W-1:0]   size_q [2];
  logic              fire, last;

  assign idle_o = (st_q == ST_IDLE);
  assign fire   = req_valid_i && idle_o;
  assign last   = pc_q || !two_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      pc_q    <= 1'b0;
      two_q   <= 1'b0;
      wr_q    <= 1'b0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      addr_q  <= '{default: '0};
      size_q  <= '{default: '0};
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (fire) begin
            if (fault_i) begin
              fault_q <= 1'b1;
            end else begin
              addr_q[0] <= addr0_i;
              addr_q[1] <= addr1_i;
              size_q[0] <= size0_i;
              size_q[1] <= size1_i;
              two_q     <= split_i;
              wr_q      <= req_write_i;
              pc_q      <= 1'b0;
              st_q      <= ST_START;
            end
          end
        end
        ST_START: st_q <= ST_WAIT;
        ST_WAIT: begin
          // retry takes priority over acknowledge
          if (retry_i) begin
            st_q <= ST_START;
          end else if (ack_i) begin
            if (last) begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
            end else begin
              pc_q <= 1'b1;
              st_q <= ST_START;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ts_o    = (st_q == ST_START);
  assign addr_o  = addr_q[pc_q];
  assign size_o  = size_q[pc_q];
  assign write_o = wr_q;
  assign done_o  = done_q;
  assign fault_o = fault_q;
endmodule

// File: rtl/mis_split_seq.sv
module mis_split_seq #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LANE_N = 8,
  parameter int unsigned MAX_B  = 4,
  parameter int unsigned WORD_B = 4,
  localparam int unsigned OFF_W = $clog2(LANE_N),
  localparam int unsigned LEN_W = $clog2(MAX_B),
  localparam int unsigned SZ_W  = $clog2(MAX_B) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              req_ext_i,
  input  logic              req_write_i,
  output logic              req_ready_o,
  input  logic              ack_i,
  input  logic              retry_i,
  output logic              ts_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [SZ_W-1:0]   bus_size_o,
  output logic [LANE_N-1:0] bus_lanes_o,
  output logic              bus_write_o,
  output logic              done_o,
  output logic              fault_o
);
  logic [SZ_W-1:0]   size0, size1;
  logic [ADDR_W-1:0] addr1;
  logic              split, flt;

  mss_split #(
    .ADDR_W(ADDR_W), .LANE_N(LANE_N), .MAX_B(MAX_B), .WORD_B(WORD_B)
  ) u_split (
    .addr_i  (req_addr_i),
    .len_i   (req_len_i),
    .ext_i   (req_ext_i),
    .size0_o (size0),
    .size1_o (size1),
    .addr1_o (addr1),
    .split_o (split),
    .fault_o (flt)
  );

  mss_seq #(
    .ADDR_W(ADDR_W), .MAX_B(MAX_B)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .fault_i     (flt),
    .split_i     (split),
    .addr0_i     (req_addr_i),
    .addr1_i     (addr1),
    .size0_i     (size0),
    .size1_i     (size1),
    .ack_i       (ack_i),
    .retry_i     (retry_i),
    .idle_o      (req_ready_o),
    .ts_o        (ts_o),
    .addr_o      (bus_addr_o),
    .size_o      (bus_size_o),
    .write_o     (bus_write_o),
    .done_o      (done_o),
    .fault_o     (fault_o)
  );

  mss_lanes #(
    .LANE_N(LANE_N), .MAX_B(MAX_B)
  ) u_lanes (
    .off_i   (bus_addr_o[OFF_W-1:0]),
    .size_i  (bus_size_o),
    .lanes_o (bus_lanes_o)
  );
endmodule

// File: rtl/mss_chk.sv
module mss_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LANE_N = 8,
  parameter int unsigned MAX_B  = 4,
  localparam int unsigned OFF_W = $clog2(LANE_N),
  localparam int unsigned SZ_W  = $clog2(MAX_B) + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              retry_i,
  input logic              ts_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [SZ_W-1:0]   bus_size_o,
  input logic [LANE_N-1:0] bus_lanes_o,
  input logic              done_o,
  input logic              fault_o
);
  AST_SIZE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts_o |-> (bus_size_o != '0 && int'(bus_size_o) <= MAX_B)); // R4
  AST_LANE_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts_o |-> ($countones(bus_lanes_o) == int'(bus_size_o))); // R5
  AST_LANE_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts_o |-> bus_lanes_o[bus_addr_o[OFF_W-1:0]]); // R5
  AST_STROBE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts_o |=> !ts_o); // R6
  AST_HOLD_TENURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_ready_o && !ts_o) |->
      ($stable(bus_addr_o) && $stable(bus_size_o) && $stable(bus_lanes_o))); // R7
  AST_RETRY_REISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retry_i && !req_ready_o && !ts_o) |=>
      (ts_o && $stable(bus_addr_o) && $stable(bus_size_o))); // R8
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (req_ready_o && !ts_o)); // R10
  AST_FAULT_NO_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (req_ready_o && !ts_o && !done_o)); // R11
endmodule

bind mis_split_seq mss_chk #(
  .ADDR_W(ADDR_W), .LANE_N(LANE_N), .MAX_B(MAX_B)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .retry_i     (retry_i),
  .ts_o        (ts_o),
  .bus_addr_o  (bus_addr_o),
  .bus_size_o  (bus_size_o),
  .bus_lanes_o (bus_lanes_o),
  .done_o      (done_o),
  .fault_o     (fault_o)
);

// File: tb/sim_mis_split_seq.sv
module sim_mis_split_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic [1:0]  req_len_i = '0;
  logic        req_ext_i = 1'b0;
  logic        req_write_i = 1'b0;
  logic        ack_i = 1'b0;
  logic        retry_i = 1'b0;
  logic        req_ready_o, ts_o, bus_write_o, done_o, fault_o;
  logic [31:0] bus_addr_o;
  logic [2:0]  bus_size_o;
  logic [7:0]  bus_lanes_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10ns clk_i = ~clk_i;

  mis_split_seq u0 (.*);

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic send(logic [31:0] a, logic [1:0] l, logic e, logic w);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = a; req_len_i = l; req_ext_i = e; req_write_i = w;
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic see_piece(string tag, logic [31:0] a, logic [2:0] s, logic [7:0] ln);
    check({tag, " strobe"}, 64'(ts_o), 64'd1);
    check({tag, " addr"},   64'(bus_addr_o), 64'(a));
    check({tag, " size"},   64'(bus_size_o), 64'(s));
    check({tag, " lanes"},  64'(bus_lanes_o), 64'(ln));
  endtask

  // from strobe negedge: wait cycles, then one acknowledge
  task automatic ack_after(int waits);
    @(negedge clk_i);
    repeat (waits) @(negedge clk_i);
    ack_i = 1'b1;
    @(negedge clk_i);
    ack_i = 1'b0;
  endtask

  task automatic retry_once();
    @(negedge clk_i);
    retry_i = 1'b1;
    @(negedge clk_i);
    retry_i = 1'b0;
  endtask

  task automatic see_done(string tag);
    check({tag, " done"},  64'(done_o), 64'd1);
    check({tag, " ready"}, 64'(req_ready_o), 64'd1);
    check({tag, " no strobe"}, 64'(ts_o), 64'd0);
    @(negedge clk_i);
    check({tag, " done one cycle"}, 64'(done_o), 64'd0);
  endtask

  task automatic t_reset();
    check("R1 ready", 64'(req_ready_o), 64'd1);
    check("R1 strobe", 64'(ts_o), 64'd0);
    check("R1 done", 64'(done_o), 64'd0);
    check("R1 fault", 64'(fault_o), 64'd0);
  endtask

  task automatic t_single();
    send(32'h1001, 2'd3, 1'b0, 1'b1);
    see_piece("R2 R4 R5 word at off1", 32'h1001, 3'b100, 8'h1E);
    check("R2 write", 64'(bus_write_o), 64'd1);
    ack_after(2);
    see_done("R2 R10 single");
  endtask

  task automatic t_stretch();
    send(32'h2000, 2'd1, 1'b0, 1'b0);
    see_piece("R4 R5 half aligned", 32'h2000, 3'b010, 8'h03);
    ack_i = 1'b1;                  // during strobe cycle: ignored
    @(negedge clk_i);
    ack_i = 1'b0;
    check("R7 early ack ignored", 64'(done_o), 64'd0);
    check("R7 still busy", 64'(req_ready_o), 64'd0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      check("R7 addr held", 64'(bus_addr_o), 64'h2000);
      check("R7 no end without ack", 64'(done_o), 64'd0);
    end
    ack_i = 1'b1;
    @(negedge clk_i);
    ack_i = 1'b0;
    see_done("R7 R10 stretched");
  endtask

  task automatic t_split(string tag, logic [31:0] a, logic [1:0] l,
                         logic [31:0] a0, logic [2:0] s0, logic [7:0] m0,
                         logic [31:0] a1, logic [2:0] s1, logic [7:0] m1);
    send(a, l, 1'b0, 1'b0);
    see_piece({tag, " R3 first"}, a0, s0, m0);
    ack_after(0);
    see_piece({tag, " R3 R6 second"}, a1, s1, m1);
    ack_after(1);
    see_done({tag, " R10"});
  endtask

  task automatic t_retry();
    send(32'h7005, 2'd3, 1'b0, 1'b0);
    see_piece("R8 first", 32'h7005, 3'b011, 8'hE0);
    retry_once();
    see_piece("R8 reissue first", 32'h7005, 3'b011, 8'hE0);
    ack_after(0);
    see_piece("R9 second", 32'h7008, 3'b001, 8'h01);
    retry_once();
    see_piece("R9 reissue only second", 32'h7008, 3'b001, 8'h01);
    ack_after(0);
    see_done("R9 R10");
  endtask

  task automatic t_retry_wins();
    send(32'h8000, 2'd0, 1'b0, 1'b0);
    see_piece("R4 R5 byte", 32'h8000, 3'b001, 8'h01);
    @(negedge clk_i);
    ack_i = 1'b1; retry_i = 1'b1;
    @(negedge clk_i);
    ack_i = 1'b0; retry_i = 1'b0;
    check("R8 retry beats ack", 64'(done_o), 64'd0);
    see_piece("R8 reissue", 32'h8000, 3'b001, 8'h01);
    ack_after(0);
    see_done("R8 R10");
  endtask

  task automatic t_ext_ok();
    send(32'h9004, 2'd0, 1'b1, 1'b0);
    see_piece("R11 ext forced 4", 32'h9004, 3'b100, 8'hF0);
    ack_after(0);
    see_done("R11 ext ok");
  endtask

  task automatic t_ext_fault(logic [31:0] a);
    send(a, 2'd3, 1'b1, 1'b0);
    check("R11 fault pulse", 64'(fault_o), 64'd1);
    check("R11 no strobe", 64'(ts_o), 64'd0);
    @(negedge clk_i);
    check("R11 fault one cycle", 64'(fault_o), 64'd0);
    check("R11 still no strobe", 64'(ts_o), 64'd0);
    check("R11 idle", 64'(req_ready_o), 64'd1);
  endtask

  task automatic t_busy();
    send(32'hA000, 2'd3, 1'b0, 1'b0);
    see_piece("R12 owner", 32'hA000, 3'b100, 8'h0F);
    req_valid_i = 1'b1; req_addr_i = 32'hB005; req_len_i = 2'd3;
    @(negedge clk_i);
    @(negedge clk_i);
    check("R12 addr unchanged", 64'(bus_addr_o), 64'hA000);
    req_valid_i = 1'b0;
    ack_i = 1'b1;
    @(negedge clk_i);
    ack_i = 1'b0;
    see_done("R12 R10");
    check("R12 no leftover strobe", 64'(ts_o), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_single();
    t_stretch();
    t_split("off5", 32'h3005, 2'd3, 32'h3005, 3'b011, 8'hE0, 32'h3008, 3'b001, 8'h01);
    t_split("off6", 32'h400E, 2'd3, 32'h400E, 3'b010, 8'hC0, 32'h4010, 3'b010, 8'h03);
    t_split("half7", 32'h5007, 2'd1, 32'h5007, 3'b001, 8'h80, 32'h5008, 3'b001, 8'h01);
    t_split("tri6", 32'h6006, 2'd2, 32'h6006, 3'b010, 8'hC0, 32'h6008, 3'b001, 8'h01);
    t_retry();
    t_retry_wins();
    t_ext_ok();
    t_ext_fault(32'h9006);
    t_ext_fault(32'h9003);
    t_busy();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R10 act=hung exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule